// File: doc/BRIEF.md
# Cascadable Clock-Enable Divide-by-N Counter

This block is a synchronous modulo-N counter. It gives the rest of a design a single-cycle clock-enable pulse at a fixed fraction of the rate of its count-enable input. The divisor `DIVISOR` is fixed when the block is built. The running count is also brought out, so that logic nearby can decode phases inside each period.

The block has no data stream, so all of its pins are plain control and status signals. Several instances can be chained: the pulse output of one stage drives the count enable of the next, and the last stage then fires once every product of the divisors. An active-high synchronous reset clears the whole block. A separate synchronous clear restarts the count from zero and overrides the count enable.

Top module: `tick_divider`

## Requirements
- R1: On a rising clock edge with `count_en` high and `clear` low, `count` advances by one. With both `count_en` and `clear` low, `count` and `tick` hold except as R4 describes.
- R2: `count` runs through 0 up to `DIVISOR-1` and then returns to 0. It is an unsigned binary value of width `$clog2(DIVISOR)`, and at least 1 bit wide.
- R3: When `clear` is high at a rising edge, `count` becomes 0 on that edge, whatever the level of `count_en`.
- R4: `tick` is high for exactly one cycle: the cycle after a cycle in which `count` was `DIVISOR-1` and `count_en` was high. In that cycle `count` reads 0. When `DIVISOR` is greater than 1, `tick` is never high in two consecutive cycles.
- R5: If `clear` is high in a cycle that would otherwise end with a wrap, no `tick` follows that cycle.
- R6: While `rst` is high at an edge, `count` and `tick` both become 0. After reset, with `count_en` held high, the first `tick` is seen after exactly `DIVISOR` edges.
- R7: With `DIVISOR` = 1, `tick` is high in each cycle that follows a cycle with `count_en` high and `clear` low.
- R8: A `count_en` left unconnected acts as tied high, and a `clear` left unconnected acts as tied low. With `DIVISOR` = 5 and both pins open, `tick` fires every 5 cycles.
- R9: When the `tick` of a stage with divisor 4 drives the `count_en` of a stage with divisor 3, the second stage's `tick` repeats every 12 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| count_en | input | 1 | Count enable (default 1) |
| clear | input | 1 | Synchronous counter clear, overrides count_en (default 0) |
| tick | output | 1 | Registered one-cycle enable pulse |
| count | output | max(1,$clog2(DIVISOR)) | Current count value |

## Verification
`count` and `tick` both come from registers. Their response to the inputs present at an edge is therefore due in the very next cycle. The pulse already carries its one-cycle lag relative to the wrap cycle, because it is registered from that cycle's condition. The bench changes its inputs on falling edges and samples on the falling edge that follows each rising edge. A cycle-accurate bench model, updated on the same rising edges, supplies the expected value in every sampled cycle. Periods and first-pulse delays are measured in whole cycles between samples.

// File: rtl/tick_div_pkg.sv
package tick_div_pkg;
  // Width of the count for a given divisor, never below one bit.
  function automatic int cnt_width(input int divisor);
    return (divisor > 1) ? $clog2(divisor) : 1;
  endfunction
endpackage

// File: rtl/tick_div_counter.sv
module tick_div_counter
  import tick_div_pkg::*;
#(
  parameter int DIVISOR = 7,
  localparam int CW = cnt_width(DIVISOR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          clr,
  output logic [CW-1:0] count,
  output logic          at_last
);
  localparam logic [CW-1:0] LAST = CW'(DIVISOR - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;

  assign at_last = (cnt_q == LAST);
  assign cnt_inc = at_last ? '0 : cnt_q + 1'b1;
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= cnt_inc;
    end
  end

  // R2
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));

  // R1
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/tick_div_pulse.sv
module tick_div_pulse (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic kill,
  output logic tick
);
  logic tick_q;

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= fire;
    end
  end

  assign tick = tick_q;

  // R6
  tick_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !tick_q);

  // R5
  clear_kills_tick_chk: assert property (@(posedge clk) disable iff (rst)
    kill |=> !tick_q);
endmodule

// File: rtl/tick_divider.sv
module tick_divider
  import tick_div_pkg::*;
#(
  parameter int DIVISOR = 7,
  localparam int CW = cnt_width(DIVISOR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          count_en = 1'b1,
  input  logic          clear = 1'b0,
  output logic          tick,
  output logic [CW-1:0] count
);
  logic at_last;
  logic wrap;

  tick_div_counter #(.DIVISOR(DIVISOR)) u_counter (
    .clk    (clk),
    .rst    (rst),
    .adv    (count_en),
    .clr    (clear),
    .count  (count),
    .at_last(at_last)
  );

  assign wrap = count_en & at_last;

  tick_div_pulse u_pulse (
    .clk (clk),
    .rst (rst),
    .fire(wrap),
    .kill(clear),
    .tick(tick)
  );

  // R4
  tick_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    tick |-> (count == '0));

  generate
    if (DIVISOR > 1) begin : g_multi
      // R4
      tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end else begin : g_unit
      // R7
      tick_every_chk: assert property (@(posedge clk) disable iff (rst)
        (count_en && !clear) |=> tick);
    end
  endgenerate
endmodule

// File: tb/tick_divider_bench.sv
module tick_divider_bench;
  localparam int DA = 7, DB = 1, DC1 = 4, DC2 = 3, DD = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic en_a = 1'b0, clr_a = 1'b0, en_b = 1'b0, clr_b = 1'b0;

  logic       tick_a, tick_b, tick_c1, tick_c2, tick_d;
  logic [2:0] cnt_a;
  logic [0:0] cnt_b;
  logic [1:0] cnt_c1, cnt_c2;
  logic [2:0] cnt_d;

  int checks = 0;
  int failures = 0;

  tick_divider #(.DIVISOR(DA)) u_tick_divider (
    .clk(clk), .rst(rst), .count_en(en_a), .clear(clr_a),
    .tick(tick_a), .count(cnt_a));
  tick_divider #(.DIVISOR(DB)) u_div1 (
    .clk(clk), .rst(rst), .count_en(en_b), .clear(clr_b),
    .tick(tick_b), .count(cnt_b));
  tick_divider #(.DIVISOR(DC1)) u_stage1 (
    .clk(clk), .rst(rst), .count_en(1'b1), .clear(1'b0),
    .tick(tick_c1), .count(cnt_c1));
  tick_divider #(.DIVISOR(DC2)) u_stage2 (
    .clk(clk), .rst(rst), .count_en(tick_c1), .clear(1'b0),
    .tick(tick_c2), .count(cnt_c2));
  // R8: count_en and clear left open
  tick_divider #(.DIVISOR(DD)) u_open (
    .clk(clk), .rst(rst), .tick(tick_d), .count(cnt_d));

  function automatic int nxt_cnt(int c, int d, bit en, bit clr, bit r);
    if (r || clr) return 0;
    if (en) return (c == d - 1) ? 0 : c + 1;
    return c;
  endfunction

  function automatic bit nxt_tick(int c, int d, bit en, bit clr, bit r);
    return !r && !clr && en && (c == d - 1);
  endfunction

  int m_ca = 0, m_cb = 0, m_c1 = 0, m_c2 = 0, m_cd = 0;
  bit m_ta = 0, m_tb = 0, m_t1 = 0, m_t2 = 0, m_td = 0;

  always @(posedge clk) begin
    m_ca <= nxt_cnt(m_ca, DA, en_a, clr_a, rst);
    m_ta <= nxt_tick(m_ca, DA, en_a, clr_a, rst);
    m_cb <= nxt_cnt(m_cb, DB, en_b, clr_b, rst);
    m_tb <= nxt_tick(m_cb, DB, en_b, clr_b, rst);
    m_c1 <= nxt_cnt(m_c1, DC1, 1'b1, 1'b0, rst);
    m_t1 <= nxt_tick(m_c1, DC1, 1'b1, 1'b0, rst);
    m_c2 <= nxt_cnt(m_c2, DC2, m_t1, 1'b0, rst);
    m_t2 <= nxt_tick(m_c2, DC2, m_t1, 1'b0, rst);
    m_cd <= nxt_cnt(m_cd, DD, 1'b1, 1'b0, rst);
    m_td <= nxt_tick(m_cd, DD, 1'b1, 1'b0, rst);
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 count a", int'(cnt_a), m_ca);
    chk("R4 tick a", int'(tick_a), int'(m_ta));
    chk("R7 count b", int'(cnt_b), m_cb);
    chk("R7 tick b", int'(tick_b), int'(m_tb));
    chk("R9 stage1 count", int'(cnt_c1), m_c1);
    chk("R9 stage2 count", int'(cnt_c2), m_c2);
    chk("R9 stage2 tick", int'(tick_c2), int'(m_t2));
    chk("R8 open count", int'(cnt_d), m_cd);
    chk("R8 open tick", int'(tick_d), int'(m_td));
  endtask

  task automatic period_of(string req, ref logic t, input int exp);
    int n;
    while (!t) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!t && n < 100);
    chk(req, n, exp);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    int held;
    void'($urandom(32'd20240613));
    repeat (3) @(negedge clk);
    // R6: reset state
    chk("R6 reset count", int'(cnt_a), 0);
    chk("R6 reset tick", int'(tick_a), 0);
    rst = 1'b0;
    en_a = 1'b1;
    n = 0;
    while (!tick_a && n < 50) begin
      @(negedge clk);
      n++;
      compare_all();
    end
    chk("R6 first tick delay", n, DA);
    chk("R4 count zero at tick", int'(cnt_a), 0);
    @(negedge clk);
    chk("R4 single cycle tick", int'(tick_a), 0);
    while (cnt_a != 3'd6) @(negedge clk);
    // R3 and R5: clear with enable in the wrap cycle
    clr_a = 1'b1;
    @(negedge clk);
    chk("R3 clear priority", int'(cnt_a), 0);
    chk("R5 tick suppressed", int'(tick_a), 0);
    clr_a = 1'b0;
    repeat (2) @(negedge clk);
    // R1: hold with enable low
    en_a = 1'b0;
    held = int'(cnt_a);
    chk("R1 advanced by two", held, 2);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1 hold count", int'(cnt_a), held);
      chk("R1 hold tick", int'(tick_a), 0);
    end
    // R7: divisor one
    en_b = 1'b1;
    @(negedge clk);
    chk("R7 tick follows enable", int'(tick_b), 1);
    en_b = 1'b0;
    @(negedge clk);
    chk("R7 tick off without enable", int'(tick_b), 0);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      compare_all();
      en_a  = ($urandom % 4) != 0;
      clr_a = ($urandom % 24) == 0;
      en_b  = ($urandom % 3) != 0;
      clr_b = ($urandom % 16) == 0;
      rst   = ($urandom % 600) == 0;
    end
    rst = 1'b0;
    en_a = 1'b1;
    clr_a = 1'b0;
    @(negedge clk);
    period_of("R9 stage1 period", tick_c1, DC1);
    period_of("R9 cascade period", tick_c2, DC1 * DC2);
    period_of("R8 open pins period", tick_d, DD);
    period_of("R2 wrap period", tick_a, DA);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule